// File: doc/BRIEF.md
# Scheduled Stream Buffer with One-Cycle Valid/Accept Handshake

This block is the flow-control datapath of one node in a statically scheduled network. It serves many virtual streams. It keeps a single word of storage per stream and does no routing. An external schedule names, one cycle ahead, which stream owns the next clock cycle (its slot). During a slot, the upstream neighbour drives a data word with a valid bit. In the same cycle the block returns an accept bit, and a word moves only when both bits are high. The block also offers the stream's stored word downstream with its own valid bit, and the word is released when the downstream accept is high.

The decision to accept is prepared in the cycle before the slot, from the stream's occupancy after the current cycle's update. A stream that is scheduled in two cycles back to back therefore sees its own preceding transfer. All storing and stalling for a blocked stream stays inside that stream's slot. The next slot, for any stream, starts from clean per-stream state.

Top module: `sched_stream_buf`

## Requirements
- R1: After reset every stream's buffer is empty. While no slot has been scheduled, `up_accept` and `dn_valid` are 0. The first slot of any stream accepts.
- R2: A word is stored into the slot stream's buffer only when `up_valid` and `up_accept` are both 1 in that slot. The stored value is `up_data` of that cycle.
- R3: In a slot whose stream buffer is full, `up_accept` is 1 only if `dn_accept` is 1 in that same slot. A full buffer is never overwritten without draining.
- R4: In a slot, `dn_valid` is 1 exactly when that stream's buffer is full, and `dn_data` then equals the stored word.
- R5: A full buffer whose slot sees `dn_accept` = 1 is emptied, unless it is refilled in the same slot.
- R6: When a full stream drains and `up_valid` is 1 in the same slot, the old word leaves on `dn_data` and the new word is stored in that cycle.
- R7: A cycle is a slot of stream k only when the previous cycle had `sched_valid` = 1 and `sched_stream` = k (k below NUM_STREAMS). Otherwise the cycle is idle: `up_accept` and `dn_valid` are 0 and no buffer changes.
- R8: A transfer or stall in one slot changes only the buffer of that slot's stream. The following slot of a different stream behaves as its own occupancy dictates.
- R9: When a stream owns two consecutive slots, the second slot's accept reflects the fill or drain made in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_valid | input | 1 | Next cycle is a scheduled slot |
| sched_stream | input | ID_W | Stream that owns the next cycle |
| up_valid | input | 1 | Upstream word present |
| up_data | input | DATA_W | Upstream word |
| up_accept | output | 1 | Slot stream takes a word this cycle |
| dn_valid | output | 1 | Stored word offered downstream |
| dn_data | output | DATA_W | Stored word of the slot stream |
| dn_accept | input | 1 | Downstream takes the offered word |

## Verification
The bench goes after a full stream offered a new word with the downstream stalled. A design that ignored occupancy there would overwrite the stored word, and the word shown on `dn_data` would be wrong later. It drives a drain and a fill in the same slot. A design that serialised them would drop accept and lose a cycle, or would clear the flag after the refill and lose the new word. It schedules the same stream in adjacent slots, which catches an accept prepared from stale occupancy. It also drives valid data during idle cycles, which exposes any design that stores words outside a slot.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  // Occupancy of one buffer after a slot: drained words leave, captured words enter.
  function automatic logic occ_after(logic held, logic drained, logic filled);
    return (held & ~drained) | filled;
  endfunction

  // Upstream accept: prepared-empty or a same-slot drain frees the word.
  function automatic logic take_rule(logic prepared_empty, logic drain_now);
    return prepared_empty | drain_now;
  endfunction
endpackage

// File: rtl/ssb_slot_reg.sv
module ssb_slot_reg #(
  parameter int NUM_STREAMS = 8,
  localparam int ID_W = $clog2(NUM_STREAMS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sched_valid,
  input  logic [ID_W-1:0] sched_stream,
  output logic            nxt_live,
  output logic            slot_live,
  output logic [ID_W-1:0] slot_id
);
  assign nxt_live = sched_valid && (int'(sched_stream) < NUM_STREAMS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_live <= 1'b0;
      slot_id   <= '0;
    end else begin
      slot_live <= nxt_live;
      slot_id   <= sched_stream;
    end
  end
endmodule

// File: rtl/ssb_accept_prep.sv
module ssb_accept_prep #(
  parameter int NUM_STREAMS = 8,
  localparam int ID_W = $clog2(NUM_STREAMS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nxt_live,
  input  logic [ID_W-1:0]        nxt_id,
  input  logic [NUM_STREAMS-1:0] occ_next,
  output logic                   prep_empty
);
  logic occ_sel;

  always_comb begin
    occ_sel = 1'b1;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (int'(nxt_id) == i) occ_sel = occ_next[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prep_empty <= 1'b0;
    else        prep_empty <= nxt_live && !occ_sel;
  end
endmodule

// File: rtl/ssb_word_bank.sv
module ssb_word_bank #(
  parameter int NUM_STREAMS = 8,
  parameter int DATA_W = 16,
  localparam int ID_W = $clog2(NUM_STREAMS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ID_W-1:0]        slot_id,
  input  logic                   fill,
  input  logic                   drain,
  input  logic [DATA_W-1:0]      wr_word,
  output logic [NUM_STREAMS-1:0] occ,
  output logic [NUM_STREAMS-1:0] occ_next,
  output logic [DATA_W-1:0]      rd_word
);
  import ssb_pkg::*;

  logic [DATA_W-1:0] word_q [NUM_STREAMS];

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    logic here;
    assign here        = (int'(slot_id) == g);
    assign occ_next[g] = occ_after(occ[g], drain && here, fill && here);

    always_ff @(posedge clk) begin
      if (!rst_n) occ[g] <= 1'b0;
      else        occ[g] <= occ_next[g];
    end

    always_ff @(posedge clk) begin
      if (fill && here) word_q[g] <= wr_word;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (int'(slot_id) == i) rd_word = word_q[i];
    end
  end
endmodule

// File: rtl/sched_stream_buf.sv
module sched_stream_buf #(
  parameter int NUM_STREAMS = 8,
  parameter int DATA_W = 16,
  localparam int ID_W = $clog2(NUM_STREAMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_valid,
  input  logic [ID_W-1:0]   sched_stream,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_accept,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_accept
);
  import ssb_pkg::*;

  logic                   nxt_live;
  logic                   slot_live;
  logic [ID_W-1:0]        slot_id;
  logic                   prep_empty;
  logic [NUM_STREAMS-1:0] occ;
  logic [NUM_STREAMS-1:0] occ_next;
  logic [DATA_W-1:0]      rd_word;
  logic                   slot_full;
  logic                   ev_drain;
  logic                   ev_fill;

  ssb_slot_reg #(.NUM_STREAMS(NUM_STREAMS)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .sched_valid(sched_valid), .sched_stream(sched_stream),
    .nxt_live(nxt_live), .slot_live(slot_live), .slot_id(slot_id)
  );

  ssb_accept_prep #(.NUM_STREAMS(NUM_STREAMS)) u_prep (
    .clk(clk), .rst_n(rst_n),
    .nxt_live(nxt_live), .nxt_id(sched_stream),
    .occ_next(occ_next), .prep_empty(prep_empty)
  );

  ssb_word_bank #(.NUM_STREAMS(NUM_STREAMS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
    .fill(ev_fill), .drain(ev_drain), .wr_word(up_data),
    .occ(occ), .occ_next(occ_next), .rd_word(rd_word)
  );

  always_comb begin
    slot_full = 1'b0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (int'(slot_id) == i) slot_full = occ[i];
    end
  end

  assign dn_valid  = slot_live && slot_full;
  assign dn_data   = rd_word;
  assign ev_drain  = dn_valid && dn_accept;
  assign up_accept = slot_live && take_rule(prep_empty, ev_drain);
  assign ev_fill   = up_valid && up_accept;
endmodule

// File: rtl/sched_stream_buf_chk.sv
module sched_stream_buf_chk #(
  parameter int NUM_STREAMS = 8,
  localparam int ID_W = $clog2(NUM_STREAMS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   slot_live,
  input logic [ID_W-1:0]        slot_id,
  input logic [NUM_STREAMS-1:0] occ,
  input logic                   ev_fill,
  input logic                   ev_drain,
  input logic                   up_accept,
  input logic                   dn_valid
);
  logic [NUM_STREAMS-1:0] sel_mask;
  assign sel_mask = slot_live ? (NUM_STREAMS'(1) << slot_id) : '0;

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> occ == '0);

  p_fill_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> occ[$past(slot_id)]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> (!occ[slot_id] || ev_drain));

  p_offer_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (slot_live && occ[slot_id]));

  p_drain_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drain && !ev_fill) |=> !occ[$past(slot_id)]);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_live |-> (!up_accept && !dn_valid));

  p_others_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((occ ^ $past(occ)) & ~$past(sel_mask)) == '0);
endmodule

bind sched_stream_buf sched_stream_buf_chk #(.NUM_STREAMS(NUM_STREAMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_live(slot_live), .slot_id(slot_id),
  .occ(occ), .ev_fill(ev_fill), .ev_drain(ev_drain),
  .up_accept(up_accept), .dn_valid(dn_valid)
);

// File: tb/sched_stream_buf_tb.sv
module sched_stream_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sched_valid = 1'b0;
  logic [2:0]    sched_stream = '0;
  logic          up_valid = 1'b0;
  logic [DW-1:0] up_data = '0;
  logic          up_accept;
  logic          dn_valid;
  logic [DW-1:0] dn_data;
  logic          dn_accept = 1'b0;

  int checks = 0;
  int fails = 0;

  // reference model state
  bit            m_full [NS];
  logic [DW-1:0] m_word [NS];
  bit            m_live = 0;
  int            m_id = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_stream_buf #(.NUM_STREAMS(NS), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_stream(sched_stream),
    .up_valid(up_valid), .up_data(up_data), .up_accept(up_accept),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_accept(dn_accept)
  );

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: current slot's stimulus plus the schedule for the next cycle.
  task automatic step(bit nv, int nid, bit iv, logic [DW-1:0] d, bit oa, string tag);
    bit e_off, e_acc, in_f, out_f;
    @(negedge clk);
    sched_valid = nv; sched_stream = 3'(nid);
    up_valid = iv; up_data = d; dn_accept = oa;
    #1;
    e_off = m_live && m_full[m_id];
    out_f = e_off && oa;
    e_acc = m_live && (!m_full[m_id] || out_f);
    in_f  = iv && e_acc;
    check(tag, "up_accept", 16'(up_accept), 16'(e_acc));
    check(tag, "dn_valid", 16'(dn_valid), 16'(e_off));
    if (e_off) check(tag, "dn_data", dn_data, m_word[m_id]);
    if (m_live) begin
      m_full[m_id] = (m_full[m_id] && !out_f) || in_f;
      if (in_f) m_word[m_id] = d;
    end
    m_live = nv && (nid < NS);
    m_id = nid;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) m_full[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing scheduled yet, quiet outputs
    step(0, 0, 1, 16'h1111, 1, "R1");
    step(0, 0, 1, 16'h2222, 0, "R1");
    // R1, R2: first slot of every stream accepts and stores
    step(1, 0, 0, 0, 0, "R1");
    for (int s = 0; s < NS; s++) step(1, (s + 1) % NS, 1, 16'(16'hA0 + s), 0, "R2");
    // slot for stream 0 is current; R3 full stream, no drain -> refuse
    step(1, 3, 1, 16'hDEAD, 0, "R3");
    step(1, 3, 1, 16'hBEEF, 0, "R3");
    // R5 drain stream 3 without new data, R9 back-to-back slot then accepts
    step(1, 3, 0, 0, 1, "R5");
    step(1, 5, 1, 16'h3333, 0, "R9");
    // R6 stream 5 full: drain and refill in one slot
    step(1, 5, 1, 16'h5555, 1, "R6");
    step(1, 2, 0, 0, 0, "R6");
    // R8 stream 2 stalls, following slot of stream 4 drains independently
    step(1, 4, 1, 16'h7777, 0, "R8");
    step(1, 2, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");
    // R7 idle cycles with valid data and accept asserted
    step(0, 0, 1, 16'h9999, 1, "R7");
    step(0, 0, 1, 16'h9998, 1, "R7");
    step(1, 2, 1, 16'h4444, 1, "R7");
    // R4 randomized traffic against the model
    for (int n = 0; n < 2000; n++)
      step(($urandom % 5) != 0, int'($urandom % NS), $urandom % 2 == 1,
           16'($urandom), ($urandom % 3) != 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule